// File: doc/BRIEF.md
# Integer Multiply and Multiply-Accumulate Unit

This unit multiplies two W-bit register operands (W = 32 by default). It returns either the low W bits of the product or the full 2W-bit product. The narrow forms are a plain multiply, a multiply that adds the product to a third operand, and a multiply that subtracts the product from that operand. The wide forms return a hi:lo pair, taken as either a signed or an unsigned product. Each wide form may add the product to a 2W-bit accumulator supplied on the request. All operands arrive as register values on the request port.

One unsigned multiplier feeds every operation. The signed product is derived from it by subtracting two shifted correction terms. The low half is the same in both signedness modes, so the narrow forms need no mode bit. A narrow plain multiply may also update two status bits: negative and zero. No other operation touches them. Two overflow indicators report whether the narrow result lost information, under the unsigned reading and under the signed reading.

A three-state controller sequences each request:
- IDLE: the unit is ready for a request.
- CALC: the product stage is registered. The unit always moves on to HOLD after one cycle.
- HOLD: the result is presented. The unit returns to IDLE when the consumer takes the result.

The transitions are IDLE→CALC on an accepted request, CALC→HOLD unconditionally, and HOLD→IDLE on `rsp_ready`.

Top module: `mac_unit`

## Requirements
- R1: After a request is accepted on a clock edge (`req_valid` and `req_ready` both high), `rsp_valid` is low after the next edge and high after the edge after that. This is a two-edge latency.
- R2: `req_ready` is high only in IDLE. While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid`, `rsp_lo`, `rsp_hi` and both overflow outputs hold their values.
- R3: Op code 3'b000 returns the low W bits of rn×rm on `rsp_lo`, with `rsp_hi` = 0. The same value results whether the operands are read as signed or as unsigned.
- R4: Op code 3'b001 returns (ra + rn×rm) mod 2^W on `rsp_lo`, with `rsp_hi` = 0.
- R5: Op code 3'b010 returns (ra − rn×rm) mod 2^W on `rsp_lo`, with `rsp_hi` = 0.
- R6: Op code 3'b100 returns the unsigned 2W-bit product as {`rsp_hi`,`rsp_lo`}, and op code 3'b110 returns the signed 2W-bit product the same way. Op codes 3'b101 and 3'b111 add the unsigned and the signed product, respectively, to {acc_hi,acc_lo}, modulo 2^2W.
- R7: Op code 3'b000 with `req_setflags` high sets `flag_n` to bit W−1 of the result and `flag_z` to (result == 0). The update lands on the same edge on which `rsp_valid` rises.
- R8: Every other op code leaves `flag_n` and `flag_z` unchanged, whatever the value of `req_setflags`. The flags also never change on edges where `rsp_valid` does not rise.
- R9: For op codes 3'b000–3'b011, `rsp_ovf_u` is 1 when the upper W bits of the unsigned product are nonzero. `rsp_ovf_s` is 1 when the upper W bits of the signed product are not the sign extension of its low half. Both are computed on the product alone, before any accumulate. Both are 0 for the wide op codes.
- R10: Op code 3'b011 returns the same result and overflow outputs as 3'b000, but never updates the flags.
- R11: During and right after reset, `req_ready` = 1, `rsp_valid` = 0, and `flag_n` = `flag_z` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit idle, request will be taken |
| req_op | input | 3 | Operation code (see R3–R10) |
| req_setflags | input | 1 | Request status-bit update (honoured only by code 000) |
| req_rn | input | W | First multiplicand |
| req_rm | input | W | Second multiplicand |
| req_ra | input | W | Addend or minuend for the narrow accumulate forms |
| req_acc_hi | input | W | Upper half of the wide accumulator |
| req_acc_lo | input | W | Lower half of the wide accumulator |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_lo | output | W | Result, low word |
| rsp_hi | output | W | Result, high word (0 for narrow forms) |
| rsp_ovf_u | output | 1 | Narrow result overflowed as unsigned |
| rsp_ovf_s | output | 1 | Narrow result overflowed as signed |
| flag_n | output | 1 | Negative status bit |
| flag_z | output | 1 | Zero status bit |

## Verification
A controller stuck in the wrong state shows within two edges of an accepted request. Either `rsp_valid` rises a cycle early or late, or `req_ready` stays high while a result is waiting. An error in the signed correction terms corrupts only `rsp_hi` of the signed wide forms and `rsp_ovf_s`, because the low half is shared. Such an error therefore surfaces on the first signed wide request with a negative operand. A flag register with a wrong update enable shows on the next handshake after a flag-setting accumulate form: its `flag_z` or `flag_n` then differs from the value left by the last plain multiply. A chained 64×64 low-half product mixes the narrow and wide forms, so a slip in either shows as a mismatch in the combined 64-bit word.

// File: rtl/mac_pkg.sv
package mac_pkg;

    typedef enum logic [2:0] {
        OP_MUL   = 3'b000,
        OP_MLA   = 3'b001,
        OP_MLS   = 3'b010,
        OP_MULQ  = 3'b011,
        OP_UMULL = 3'b100,
        OP_UMLAL = 3'b101,
        OP_SMULL = 3'b110,
        OP_SMLAL = 3'b111
    } mac_op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CALC = 2'd1,
        ST_HOLD = 2'd2
    } mac_state_e;

    // Wide forms carry bit 2 of the op code.
    function automatic logic op_is_wide(input mac_op_e op);
        return op[2];
    endfunction

endpackage

// File: rtl/mac_fsm.sv
module mac_fsm
    import mac_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic rsp_ready,
    output logic req_ready,
    output logic rsp_valid,
    output logic load_prod,
    output logic load_res
);

    mac_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d   = state_q;
        req_ready = 1'b0;
        rsp_valid = 1'b0;
        load_prod = 1'b0;
        load_res  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                req_ready = 1'b1;
                if (req_valid) begin
                    load_prod = 1'b1;
                    state_d   = ST_CALC;
                end
            end
            ST_CALC: begin
                load_res = 1'b1;
                state_d  = ST_HOLD;
            end
            ST_HOLD: begin
                rsp_valid = 1'b1;
                if (rsp_ready) begin
                    state_d = ST_IDLE;
                end
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

endmodule

// File: rtl/mac_prod.sv
module mac_prod
    import mac_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  mac_op_e      op,
    input  logic         setf,
    input  logic [W-1:0] rn,
    input  logic [W-1:0] rm,
    input  logic [W-1:0] ra,
    input  logic [W-1:0] acc_hi,
    input  logic [W-1:0] acc_lo,
    output logic [2*W-1:0] prod_u_q,
    output logic [2*W-1:0] prod_s_q,
    output mac_op_e      op_q,
    output logic         setf_q,
    output logic [W-1:0] ra_q,
    output logic [2*W-1:0] acc_q
);

    localparam int PW = 2 * W;

    logic [PW-1:0] rn_ext, rm_ext, prod_u_c, corr_rn, corr_rm, prod_s_c;

    // One unsigned array; the signed product removes 2^W * (other operand)
    // for each operand whose top bit is set.
    always_comb begin
        rn_ext   = {{W{1'b0}}, rn};
        rm_ext   = {{W{1'b0}}, rm};
        prod_u_c = rn_ext * rm_ext;
        corr_rn  = rn[W-1] ? {rm, {W{1'b0}}} : '0;
        corr_rm  = rm[W-1] ? {rn, {W{1'b0}}} : '0;
        prod_s_c = prod_u_c - corr_rn - corr_rm;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prod_u_q <= '0;
            prod_s_q <= '0;
            op_q     <= OP_MUL;
            setf_q   <= 1'b0;
            ra_q     <= '0;
            acc_q    <= '0;
        end else if (load) begin
            prod_u_q <= prod_u_c;
            prod_s_q <= prod_s_c;
            op_q     <= op;
            setf_q   <= setf;
            ra_q     <= ra;
            acc_q    <= {acc_hi, acc_lo};
        end
    end

endmodule

// File: rtl/mac_result.sv
module mac_result
    import mac_pkg::*;
#(
    parameter int W = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic [2*W-1:0] prod_u,
    input  logic [2*W-1:0] prod_s,
    input  mac_op_e        op,
    input  logic           setf,
    input  logic [W-1:0]   ra,
    input  logic [2*W-1:0] acc,
    output logic [W-1:0]   res_lo,
    output logic [W-1:0]   res_hi,
    output logic           ovf_u,
    output logic           ovf_s,
    output logic           flag_n,
    output logic           flag_z
);

    localparam int PW = 2 * W;

    logic [PW-1:0] wide_c;
    logic [W-1:0]  low_c;
    logic [W-1:0]  narrow_c;
    logic          ovf_u_c, ovf_s_c, flag_we;

    always_comb begin
        low_c    = prod_u[W-1:0];
        narrow_c = low_c;
        wide_c   = '0;
        unique case (op)
            OP_MUL:   narrow_c = low_c;
            OP_MULQ:  narrow_c = low_c;
            OP_MLA:   narrow_c = ra + low_c;
            OP_MLS:   narrow_c = ra - low_c;
            OP_UMULL: wide_c   = prod_u;
            OP_UMLAL: wide_c   = acc + prod_u;
            OP_SMULL: wide_c   = prod_s;
            OP_SMLAL: wide_c   = acc + prod_s;
            default:  narrow_c = low_c;
        endcase
        ovf_u_c = !op_is_wide(op) && (|prod_u[PW-1:W]);
        ovf_s_c = !op_is_wide(op) && (prod_s[PW-1:W] != {W{prod_s[W-1]}});
        flag_we = load && (op == OP_MUL) && setf;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_lo <= '0;
            res_hi <= '0;
            ovf_u  <= 1'b0;
            ovf_s  <= 1'b0;
        end else if (load) begin
            res_lo <= op_is_wide(op) ? wide_c[W-1:0]  : narrow_c;
            res_hi <= op_is_wide(op) ? wide_c[PW-1:W] : '0;
            ovf_u  <= ovf_u_c;
            ovf_s  <= ovf_s_c;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_n <= 1'b0;
            flag_z <= 1'b0;
        end else if (flag_we) begin
            flag_n <= narrow_c[W-1];
            flag_z <= (narrow_c == '0);
        end
    end

endmodule

// File: rtl/mac_unit.sv
module mac_unit
    import mac_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         req_valid,
    output logic         req_ready,
    input  logic [2:0]   req_op,
    input  logic         req_setflags,
    input  logic [W-1:0] req_rn,
    input  logic [W-1:0] req_rm,
    input  logic [W-1:0] req_ra,
    input  logic [W-1:0] req_acc_hi,
    input  logic [W-1:0] req_acc_lo,
    output logic         rsp_valid,
    input  logic         rsp_ready,
    output logic [W-1:0] rsp_lo,
    output logic [W-1:0] rsp_hi,
    output logic         rsp_ovf_u,
    output logic         rsp_ovf_s,
    output logic         flag_n,
    output logic         flag_z
);

    localparam int PW = 2 * W;

    logic          load_prod, load_res;
    logic [PW-1:0] prod_u_q, prod_s_q, acc_q;
    mac_op_e       op_q;
    logic          setf_q;
    logic [W-1:0]  ra_q;

    mac_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .rsp_ready (rsp_ready),
        .req_ready (req_ready),
        .rsp_valid (rsp_valid),
        .load_prod (load_prod),
        .load_res  (load_res)
    );

    mac_prod #(.W(W)) u_prod (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load_prod),
        .op       (mac_op_e'(req_op)),
        .setf     (req_setflags),
        .rn       (req_rn),
        .rm       (req_rm),
        .ra       (req_ra),
        .acc_hi   (req_acc_hi),
        .acc_lo   (req_acc_lo),
        .prod_u_q (prod_u_q),
        .prod_s_q (prod_s_q),
        .op_q     (op_q),
        .setf_q   (setf_q),
        .ra_q     (ra_q),
        .acc_q    (acc_q)
    );

    mac_result #(.W(W)) u_result (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (load_res),
        .prod_u (prod_u_q),
        .prod_s (prod_s_q),
        .op     (op_q),
        .setf   (setf_q),
        .ra     (ra_q),
        .acc    (acc_q),
        .res_lo (rsp_lo),
        .res_hi (rsp_hi),
        .ovf_u  (rsp_ovf_u),
        .ovf_s  (rsp_ovf_s),
        .flag_n (flag_n),
        .flag_z (flag_z)
    );

endmodule

// File: rtl/mac_unit_chk.sv
module mac_unit_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         req_valid,
    input logic         req_ready,
    input logic         rsp_valid,
    input logic         rsp_ready,
    input logic [W-1:0] rsp_lo,
    input logic [W-1:0] rsp_hi,
    input logic         rsp_ovf_u,
    input logic         rsp_ovf_s,
    input logic         flag_n,
    input logic         flag_z
);

    AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !rsp_valid ##1 rsp_valid); // R1

    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready); // R2

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> rsp_valid && $stable(rsp_lo) && $stable(rsp_hi)
            && $stable(rsp_ovf_u) && $stable(rsp_ovf_s)); // R2

    AST_FLAGS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(rsp_valid) |-> $stable({flag_n, flag_z})); // R8

    AST_FLAG_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rsp_valid) && !$stable({flag_n, flag_z}))
            |-> (flag_z == (rsp_lo == '0)) && (flag_n == rsp_lo[W-1])); // R7

    AST_WIDE_NO_OVF: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_hi != '0) |-> !rsp_ovf_u && !rsp_ovf_s); // R9

endmodule

bind mac_unit mac_unit_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .rsp_lo    (rsp_lo),
    .rsp_hi    (rsp_hi),
    .rsp_ovf_u (rsp_ovf_u),
    .rsp_ovf_s (rsp_ovf_s),
    .flag_n    (flag_n),
    .flag_z    (flag_z)
);

// File: tb/test_mac_unit.sv
module test_mac_unit;

    localparam int W = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [2:0]  req_op = '0;
    logic        req_setflags = 1'b0;
    logic [31:0] req_rn = '0, req_rm = '0, req_ra = '0, req_acc_hi = '0, req_acc_lo = '0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b1;
    logic [31:0] rsp_lo, rsp_hi;
    logic        rsp_ovf_u, rsp_ovf_s, flag_n, flag_z;

    always #4 clk = ~clk;

    mac_unit #(.W(W)) i_mac_unit (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_setflags(req_setflags), .req_rn(req_rn), .req_rm(req_rm),
        .req_ra(req_ra), .req_acc_hi(req_acc_hi), .req_acc_lo(req_acc_lo),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_lo(rsp_lo), .rsp_hi(rsp_hi),
        .rsp_ovf_u(rsp_ovf_u), .rsp_ovf_s(rsp_ovf_s), .flag_n(flag_n), .flag_z(flag_z)
    );

    typedef struct {
        logic [31:0] lo, hi;
        logic        ovu, ovs, fn, fz;
        int          due;
        string       req;
    } exp_t;

    exp_t exp_q[$];
    int   n_chk = 0, n_fail = 0, cyc = 0;
    logic mdl_n = 1'b0, mdl_z = 1'b0;
    logic [31:0] last_lo, last_hi;
    bit   done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, expv);
        end
    endtask

    function automatic void model(input logic [2:0] op, input logic [31:0] rn, rm, ra,
                                  input logic [63:0] acc, output logic [31:0] lo, hi,
                                  output logic ovu, ovs);
        logic [63:0] pu, ps, w;
        pu = {32'b0, rn} * {32'b0, rm};
        ps = $signed({{32{rn[31]}}, rn}) * $signed({{32{rm[31]}}, rm});
        ovu = 1'b0; ovs = 1'b0; hi = '0; lo = pu[31:0];
        if (!op[2]) begin
            ovu = (pu[63:32] != 0);
            ovs = (ps[63:32] != {32{ps[31]}});
            case (op)
                3'b001:  lo = ra + pu[31:0];
                3'b010:  lo = ra - pu[31:0];
                default: lo = pu[31:0];
            endcase
        end else begin
            case (op)
                3'b100:  w = pu;
                3'b101:  w = acc + pu;
                3'b110:  w = ps;
                default: w = acc + ps;
            endcase
            lo = w[31:0]; hi = w[63:32];
        end
    endfunction

    // Driver: computes the expected item, pushes it, and presents the request.
    task automatic send(input logic [2:0] op, input logic sf, input logic [31:0] rn, rm, ra,
                        input logic [63:0] acc, input string req);
        exp_t e;
        model(op, rn, rm, ra, acc, e.lo, e.hi, e.ovu, e.ovs);
        if (op == 3'b000 && sf) begin
            mdl_n = e.lo[31];
            mdl_z = (e.lo == 0);
        end
        e.fn = mdl_n; e.fz = mdl_z; e.req = req;
        @(negedge clk);
        req_op = op; req_setflags = sf; req_rn = rn; req_rm = rm; req_ra = ra;
        req_acc_hi = acc[63:32]; req_acc_lo = acc[31:0]; req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        e.due = cyc + 2;
        exp_q.push_back(e);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    // Monitor / scoreboard
    bit seen = 0, held = 0;
    logic [31:0] held_lo, held_hi;
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (exp_q.size() == 0) begin
                chk(0, "R1 unexpected result", {32'b0, rsp_lo}, 64'h0);
            end else begin
                if (!seen) begin
                    seen = 1;
                    chk(cyc == exp_q[0].due, "R1 latency", 64'(cyc), 64'(exp_q[0].due));
                end
                chk(!req_ready, "R2 ready low while busy", {63'b0, req_ready}, 64'h0);
                if (held) begin
                    chk({rsp_hi, rsp_lo} == {held_hi, held_lo}, "R2 hold", {rsp_hi, rsp_lo}, {held_hi, held_lo});
                end
                if (rsp_ready) begin
                    chk({rsp_hi, rsp_lo} == {exp_q[0].hi, exp_q[0].lo}, exp_q[0].req,
                        {rsp_hi, rsp_lo}, {exp_q[0].hi, exp_q[0].lo});
                    chk({rsp_ovf_u, rsp_ovf_s} == {exp_q[0].ovu, exp_q[0].ovs}, "R9 overflow",
                        {62'b0, rsp_ovf_u, rsp_ovf_s}, {62'b0, exp_q[0].ovu, exp_q[0].ovs});
                    chk({flag_n, flag_z} == {exp_q[0].fn, exp_q[0].fz}, "R7/R8 flags",
                        {62'b0, flag_n, flag_z}, {62'b0, exp_q[0].fn, exp_q[0].fz});
                    last_lo = rsp_lo; last_hi = rsp_hi;
                    void'(exp_q.pop_front());
                    seen = 0; held = 0;
                end else begin
                    held = 1; held_lo = rsp_lo; held_hi = rsp_hi;
                end
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    // 64x64 low-half product from three operations
    task automatic chain(input logic [63:0] a, input logic [63:0] b);
        logic [31:0] t0, t1, dh, dl;
        logic        u0, u1;
        logic [63:0] full;
        model(3'b000, a[63:32], b[31:0], 0, 0, t0, dh, u0, u1);
        send(3'b000, 1'b0, a[63:32], b[31:0], 0, 0, "R3 chain step1");
        model(3'b001, a[31:0], b[63:32], t0, 0, t1, dh, u0, u1);
        send(3'b001, 1'b0, a[31:0], b[63:32], t0, 0, "R4 chain step2");
        send(3'b100, 1'b0, a[31:0], b[31:0], 0, 0, "R6 chain step3");
        drain();
        dl = last_lo;
        full = a * b;
        chk({t1 + last_hi, dl} == full, "R6 chain 64x64 low product", {t1 + last_hi, dl}, full);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(req_ready == 1'b1 && rsp_valid == 1'b0, "R11 reset handshake", {62'b0, req_ready, rsp_valid}, 64'h2);
        chk({flag_n, flag_z} == 2'b00, "R11 reset flags", {62'b0, flag_n, flag_z}, 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1 && rsp_valid == 1'b0, "R11 after reset", {62'b0, req_ready, rsp_valid}, 64'h2);

        send(3'b000, 1'b1, 32'd12, 32'd13, 0, 0, "R3 mul small");
        send(3'b000, 1'b1, 32'hFFFF_FFFC, 32'hFFFF_FFFD, 0, 0, "R3 mul neg patterns");
        send(3'b000, 1'b1, 32'd0, 32'd5, 0, 0, "R7 zero flag");
        send(3'b000, 1'b1, 32'h8000_0000, 32'd1, 0, 0, "R7 negative flag");
        send(3'b001, 1'b1, 32'd0, 32'd0, 32'd0, 0, "R8 mla with setflags");
        send(3'b001, 1'b0, 32'd7, 32'd9, 32'd100, 0, "R4 mla");
        send(3'b010, 1'b0, 32'd7, 32'd9, 32'd100, 0, "R5 mls");
        send(3'b010, 1'b1, 32'd5, 32'd1, 32'd0, 0, "R5 mls wraps negative");
        send(3'b011, 1'b1, 32'd0, 32'd0, 0, 0, "R10 reserved code no flags");
        send(3'b011, 1'b0, 32'h0001_0000, 32'h0000_8000, 0, 0, "R10 reserved code result");
        send(3'b000, 1'b0, 32'h0001_0000, 32'h0000_8000, 0, 0, "R9 signed-only overflow");
        send(3'b100, 1'b1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 0, "R6 umull");
        send(3'b110, 1'b1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 0, "R6 smull");
        send(3'b101, 1'b0, 32'hFFFF_FFFF, 32'h2, 0, 64'h0000_0001_FFFF_FFFF, "R6 umlal carry");
        send(3'b111, 1'b0, 32'hFFFF_FFFE, 32'd3, 0, 64'd10, "R6 smlal");
        drain();

        rsp_ready = 1'b0;
        send(3'b000, 1'b0, 32'd6, 32'd7, 0, 0, "R2 backpressure result");
        repeat (4) @(negedge clk);
        chk(rsp_valid == 1'b1, "R2 valid held", {63'b0, rsp_valid}, 64'h1);
        rsp_ready = 1'b1;
        drain();

        chain(64'h1234_5678_9ABC_DEF0, 64'h0FED_CBA9_8765_4321);
        chain(64'hFFFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0001);

        for (int i = 0; i < 40; i++) begin
            send(3'($urandom), 1'($urandom), $urandom, $urandom, $urandom,
                 {$urandom, $urandom}, "R3-R10 mixed");
        end
        drain();
        finish_run();
    end

endmodule